// File: doc/BRIEF.md
# Phase-Frequency Detector with Digital Lock Filter

This block compares two divided pulse trains, a reference train and a VCO train, inside a synthesizer control loop. Both trains are sampled on the reference oscillator clock. A rising edge on either train sets an up or down latch. When both latches are set, they are held together for a fixed number of clocks and then cleared. This ends one comparison cycle and guarantees pump pulses of finite width even when the loop is in phase.

From the latch pair the block derives three kinds of pump control:
- a charge-pump drive level with a separate output enable standing for high impedance;
- a level and an open-drain pull for an external pump;
- a polarity setting for a VCO with a falling tuning curve.

A digital lock filter counts the clocks in which only one latch is set. It declares lock after several consecutive comparison cycles with an error under two oscillator periods. A status pin carries either the lock flag or one of the raw pulse trains. An enable input puts the block into power-down, and a pump-on input tri-states the charge pump on its own.

Top module: `pfd_lockdet`

## Requirements
- R1: A rising edge of `ref_in` (or `vco_in`) seen at a clock edge sets `pump_up` (or `pump_dn`) visible right after that same edge. `pump_up` alone high means the reference leads, and `pump_dn` alone high means the VCO leads.
- R2: Once both `pump_up` and `pump_dn` are high, both stay high for exactly RST_HOLD clocks (default 2) and then clear together. This ends a comparison cycle. A new input edge arriving on the clearing edge sets its latch again and is not lost.
- R3: With `pol_pos`=1, reference-leads gives `cp_oe`=1 and `cp_level`=1, and VCO-leads gives `cp_oe`=1 and `cp_level`=0. With `pol_pos`=0 these two cases swap. When both latches are equal, `cp_oe`=0 and `cp_level`=0.
- R4: `pump_on`=0 forces `cp_oe`=0 and `cp_level`=0 whatever the phase.
- R5: In the case where `cp_level` would be 0 under the current polarity (the "low" case), `ext_r`=1 and `ext_p_oe`=1. Here `ext_p_oe`=1 means the open-drain pin pulls low. In every other case `ext_r`=0 and `ext_p_oe`=0. This holds independent of `pump_on`.
- R6: The phase error of a comparison cycle is the number of clocks with exactly one latch set. `lock_out` goes to 1 after LOCK_CNT (default 3) consecutive comparison cycles with an error below ERR_WIN (default 2). A cycle with an error of ERR_WIN or more returns it to 0.
- R7: With `run`=0 the following hold:
  - `lock_out` is 1 and `cp_oe` is 0;
  - both latches are held clear and input edges are ignored;
  - the consecutive-good count restarts from zero, so lock needs LOCK_CNT fresh good cycles after `run` returns to 1.
- R8: `stat_out` equals `lock_out` when `stat_sel`=0. When `stat_sel`=1 it equals `ref_in` if `pol_pos`=1 and `vco_in` if `pol_pos`=0.
- R9: During and after reset, `pump_up`, `pump_dn`, `cp_oe`, `cp_level`, `ext_r`, `ext_p_oe` and `lock_out` (with `run`=1) are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Divided reference pulse train |
| vco_in | input | 1 | Divided VCO pulse train |
| run | input | 1 | 1 = active, 0 = power-down |
| pump_on | input | 1 | 0 = charge pump forced to high impedance |
| pol_pos | input | 1 | 1 = rising VCO tuning curve, 0 = falling |
| stat_sel | input | 1 | 0 = status shows lock, 1 = status shows a pulse train |
| pump_up | output | 1 | Reference-side detector latch |
| pump_dn | output | 1 | VCO-side detector latch |
| cp_level | output | 1 | Charge-pump drive level |
| cp_oe | output | 1 | Charge-pump drive enable (0 = high impedance) |
| ext_r | output | 1 | External pump level output |
| ext_p_oe | output | 1 | External open-drain pull-low enable |
| lock_out | output | 1 | Lock-detect flag |
| stat_out | output | 1 | Multiplexed status output |

## Verification
The end of a comparison cycle, where both latches clear, can fall in the same clock as a fresh reference edge that must open the next cycle. The bench provokes this by sending coincident edges and then a second reference edge exactly RST_HOLD clocks later. It expects `pump_up` set alone right after that edge, and the following VCO edge to give a one-clock error that counts toward lock. A sweep over polarity, pump-on, status select and offsets from -3 to +3 clocks checks every output against arithmetic expectations, and runs of repeated pairs show lock being gained and lost.

// File: rtl/pfdl_pkg.sv
package pfdl_pkg;
  typedef enum logic [1:0] {
    PH_EQUAL    = 2'd0,
    PH_REF_LEAD = 2'd1,
    PH_VCO_LEAD = 2'd2
  } phase_e;
endpackage

// File: rtl/pfdl_core.sv
module pfdl_core #(
  parameter int RST_HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ref_in,
  input  logic vco_in,
  output logic up_q,
  output logic dn_q,
  output logic cmp_done
);
  localparam int HW = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD - 1);

  logic ref_q, vco_q;
  logic ref_rise, vco_rise, both, clr;
  logic up_d, dn_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    ref_rise = ref_in & ~ref_q;
    vco_rise = vco_in & ~vco_q;
    both     = up_q & dn_q;
    clr      = both && (hold_q == HOLD_LAST);
    up_d     = run & (ref_rise | (up_q & ~clr));
    dn_d     = run & (vco_rise | (dn_q & ~clr));
    if (!run || !both || clr) hold_d = '0;
    else                      hold_d = hold_q + 1'b1;
    cmp_done = clr & run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      vco_q  <= 1'b0;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      ref_q  <= ref_in;
      vco_q  <= vco_in;
      up_q   <= up_d;
      dn_q   <= dn_d;
      hold_q <= hold_d;
    end
  end

  generate
    if (RST_HOLD > 1) begin : g_minw
      AST_BOTH_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n || !run)
        (up_q && dn_q && hold_q == '0) |=> (up_q && dn_q)); // R2
    end
  endgenerate

  AST_PWRDN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!up_q && !dn_q)); // R7
endmodule

// File: rtl/pfdl_lockfilt.sv
module pfdl_lockfilt #(
  parameter int ERR_WIN  = 2,
  parameter int LOCK_CNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic up_q,
  input  logic dn_q,
  input  logic cmp_done,
  output logic locked
);
  localparam int EW = $clog2(ERR_WIN + 1);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam logic [EW-1:0] ERR_MAX  = EW'(ERR_WIN);
  localparam logic [GW-1:0] GOOD_MAX = GW'(LOCK_CNT);

  logic [EW-1:0] err_q, err_d;
  logic [GW-1:0] good_q, good_d;

  always_comb begin
    err_d  = err_q;
    good_d = good_q;
    if (!run || cmp_done)                    err_d = '0;
    else if ((up_q ^ dn_q) && err_q != ERR_MAX) err_d = err_q + 1'b1;

    if (!run) good_d = '0;
    else if (cmp_done) begin
      if (err_q < ERR_MAX) good_d = (good_q == GOOD_MAX) ? good_q : good_q + 1'b1;
      else                 good_d = '0;
    end else if (err_q == ERR_MAX) good_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
    end else begin
      err_q  <= err_d;
      good_q <= good_d;
    end
  end

  assign locked = (good_q == GOOD_MAX);

  AST_LOCK_RISE_ON_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cmp_done)); // R6
  AST_LOCK_LOST_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmp_done && err_q >= ERR_MAX) |=> !locked); // R6
endmodule

// File: rtl/pfdl_drive.sv
module pfdl_drive
  import pfdl_pkg::*;
(
  input  logic up_q,
  input  logic dn_q,
  input  logic pol_pos,
  input  logic pump_on,
  input  logic run,
  output logic cp_level,
  output logic cp_oe,
  output logic ext_r,
  output logic ext_p_oe
);
  phase_e phase;
  logic   src_hi, src_lo;

  always_comb begin
    if (up_q && !dn_q)      phase = PH_REF_LEAD;
    else if (dn_q && !up_q) phase = PH_VCO_LEAD;
    else                    phase = PH_EQUAL;
    src_hi   = pol_pos ? (phase == PH_REF_LEAD) : (phase == PH_VCO_LEAD);
    src_lo   = pol_pos ? (phase == PH_VCO_LEAD) : (phase == PH_REF_LEAD);
    cp_oe    = run & pump_on & (phase != PH_EQUAL);
    cp_level = cp_oe & src_hi;
    ext_r    = src_lo;
    ext_p_oe = src_lo;
  end
endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet #(
  parameter int RST_HOLD = 2,
  parameter int ERR_WIN  = 2,
  parameter int LOCK_CNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic vco_in,
  input  logic run,
  input  logic pump_on,
  input  logic pol_pos,
  input  logic stat_sel,
  output logic pump_up,
  output logic pump_dn,
  output logic cp_level,
  output logic cp_oe,
  output logic ext_r,
  output logic ext_p_oe,
  output logic lock_out,
  output logic stat_out
);
  logic rst_m, rst_s;
  logic cmp_done, locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  pfdl_core #(.RST_HOLD(RST_HOLD)) u_core (
    .clk(clk), .rst_n(rst_s), .run(run), .ref_in(ref_in), .vco_in(vco_in),
    .up_q(pump_up), .dn_q(pump_dn), .cmp_done(cmp_done)
  );

  pfdl_lockfilt #(.ERR_WIN(ERR_WIN), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk(clk), .rst_n(rst_s), .run(run), .up_q(pump_up), .dn_q(pump_dn),
    .cmp_done(cmp_done), .locked(locked)
  );

  pfdl_drive u_drive (
    .up_q(pump_up), .dn_q(pump_dn), .pol_pos(pol_pos), .pump_on(pump_on),
    .run(run), .cp_level(cp_level), .cp_oe(cp_oe), .ext_r(ext_r), .ext_p_oe(ext_p_oe)
  );

  always_comb begin
    lock_out = ~run | locked;
    stat_out = stat_sel ? (pol_pos ? ref_in : vco_in) : lock_out;
  end

  AST_PD_LOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_s)
    !run |-> lock_out); // R7
  AST_ZC_HIZ: assert property (@(posedge clk) disable iff (!rst_s)
    !pump_on |-> (!cp_oe && !cp_level)); // R4
  AST_EXT_PAIR: assert property (@(posedge clk) disable iff (!rst_s)
    ext_p_oe |-> (ext_r && (pump_up != pump_dn))); // R5
  AST_CP_ONE_SIDED: assert property (@(posedge clk) disable iff (!rst_s)
    cp_oe |-> (pump_up != pump_dn)); // R3
endmodule

// File: tb/pfd_lockdet_test.sv
module pfd_lockdet_test;
  localparam int HOLD = 2;
  localparam int PER  = 12;

  logic clk = 1'b0;
  logic rst_n, ref_in, vco_in, run, pump_on, pol_pos, stat_sel;
  logic pump_up, pump_dn, cp_level, cp_oe, ext_r, ext_p_oe, lock_out, stat_out;
  int checks = 0;
  int errors = 0;
  int good = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfd_lockdet uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in), .run(run),
    .pump_on(pump_on), .pol_pos(pol_pos), .stat_sel(stat_sel),
    .pump_up(pump_up), .pump_dn(pump_dn), .cp_level(cp_level), .cp_oe(cp_oe),
    .ext_r(ext_r), .ext_p_oe(ext_p_oe), .lock_out(lock_out), .stat_out(stat_out)
  );

  task automatic chk(input string req, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, name, act, exp, $time);
    end
  endtask

  // drive one clock of inputs, then check outputs right after the edge
  task automatic step(input logic r, input logic v, input logic eu, input logic ed, input bit chk_lock);
    logic rl, vl, hi, lo, eoe, lk;
    @(negedge clk);
    ref_in = r;
    vco_in = v;
    @(posedge clk);
    #1;
    rl  = eu & ~ed;
    vl  = ed & ~eu;
    hi  = pol_pos ? rl : vl;
    lo  = pol_pos ? vl : rl;
    eoe = run & pump_on & (rl | vl);
    lk  = ~run | (good >= 3);
    chk("R1", "pump_up", pump_up, eu);
    chk("R2", "pump_dn", pump_dn, ed);
    chk(pump_on ? "R3" : "R4", "cp_oe", cp_oe, eoe);
    chk("R3", "cp_level", cp_level, eoe & hi);
    chk("R5", "ext_r", ext_r, lo);
    chk("R5", "ext_p_oe", ext_p_oe, lo);
    if (stat_sel) chk("R8", "stat_out", stat_out, pol_pos ? r : v);
    if (chk_lock) begin
      chk(run ? "R6" : "R7", "lock_out", lock_out, lk);
      if (!stat_sel) chk("R8", "stat_out", stat_out, lk);
    end
  endtask

  // one comparison cycle: reference edge at kr, VCO edge at kv
  task automatic run_pair(input int kr, input int kv);
    int lag = (kr > kv) ? kr : kv;
    int k   = (kr > kv) ? kr - kv : kv - kr;
    for (int s = 0; s < PER; s++) begin
      if (s == lag + HOLD) good = (k < 2) ? ((good < 3) ? good + 1 : 3) : 0;
      step(s == kr, s == kv,
           (s >= kr) && (s <= lag + HOLD - 1),
           (s >= kv) && (s <= lag + HOLD - 1),
           s == PER - 1);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_in = 0; vco_in = 0; run = 1; pump_on = 1; pol_pos = 1; stat_sel = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "pump_up", pump_up, 1'b0);
    chk("R9", "pump_dn", pump_dn, 1'b0);
    chk("R9", "cp_oe", cp_oe, 1'b0);
    chk("R9", "lock_out", lock_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 1);
    chk("R9", "ext_p_oe", ext_p_oe, 1'b0);

    // sweep: polarity, pump-on, status select, offsets -3..+3
    for (int f = 0; f < 2; f++)
      for (int z = 0; z < 2; z++)
        for (int l = 0; l < 2; l++)
          for (int d = -3; d <= 3; d++) begin
            pol_pos = f[0]; pump_on = z[0]; stat_sel = l[0];
            for (int n = 0; n < 3; n++) run_pair(3, 3 + d);
          end

    // lock built, then power-down: R7
    pol_pos = 1; pump_on = 1; stat_sel = 0;
    for (int n = 0; n < 3; n++) run_pair(2, 3);
    @(negedge clk);
    run = 0;
    good = 0;
    for (int s = 0; s < 6; s++) step(s == 1, s == 3, 0, 0, 1);
    @(negedge clk);
    run = 1;
    step(0, 0, 0, 0, 1);
    run_pair(3, 3);
    chk("R7", "lock_out after restart", lock_out, 1'b0);

    // R2: new reference edge on the clearing edge
    good = 0;
    @(negedge clk); run = 0;
    @(negedge clk); run = 1;
    step(1, 1, 1, 1, 0);
    step(0, 0, 1, 1, 0);
    step(1, 0, 1, 0, 0);
    step(0, 1, 1, 1, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0);
    good = 2;
    step(0, 0, 0, 0, 1);
    run_pair(3, 3);
    chk("R6", "lock after coincident sequence", lock_out, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule